// File: doc/BRIEF.md
# Floppy Head Step Sequencer

This block runs the head-positioning commands of a floppy disk controller. A host presents an 8-bit command byte together with a target track. The sequencer then drives a step pulse and a direction line toward the drive until the head reaches its goal. It keeps an 8-bit track register. It reads the drive's track-zero sensor and index line, and it reports busy, not-at-track-zero and a record-not-found flag.

Five operations share one opcode family, selected by the upper command bits:
- `0000`: return to track zero (restore).
- `0001`: seek.
- `001`: step in the last direction.
- `010`: step inward.
- `011`: step outward.

A two-bit rate code and a table-select input together pick the step period. A verify bit adds a fixed settling delay and then waits for an external verify-pass strobe. A spin-up-skip bit decides whether the sequencer first waits for a motor-ready input. All millisecond delays are multiples of the parameter `CYC_PER_MS`.

The controller is a single state machine with six states:
- IDLE accepts a command and goes either to SPIN or to DECIDE.
- SPIN goes to DECIDE once the motor is ready.
- DECIDE either issues a step (to STEP) or finishes.
- STEP returns to DECIDE (restore, seek) or finishes (the single-step kinds) when its period ends.
- Finishing goes to IDLE, or to SETTLE when verify is set.
- SETTLE goes to VERIFY after the settle time.
- VERIFY goes to IDLE on a verify-pass strobe, or on the fifth index edge with record-not-found set.
- DECIDE in restore goes to IDLE with record-not-found after 255 steps without reaching track zero.

Top module: `head_step_seq`

## Requirements
- R1: A command is accepted only in IDLE with `cmd_valid_i` high and an opcode of restore `0000`, seek `0001`, step `001`, step-in `010` or step-out `011` in bits 7:4 (or 7:5). Any byte with bit 7 set, and any command that arrives while busy, has no effect.
- R2: Rate bits 1:0 pick the step period as a number of milliseconds times `CYC_PER_MS` cycles. With `rate_tbl_i`=0 the codes 0..3 give 6, 12, 20 and 30 ms. With `rate_tbl_i`=1 they give 6, 12, 2 and 3 ms. The table is sampled when the command is accepted.
- R3: Seek compares the track register with the target latched at acceptance. It steps toward the target, inward when the target is larger, and updates the track register by one per step. It ends when the two are equal. For k steps of period P, busy lasts k·(P+1)+1 cycles.
- R4: Restore steps outward until the track-zero input is seen and then loads 0 into the track register.
- R5: A restore that has issued 255 steps without seeing track zero ends and sets `rnf_o`. `rnf_o` clears when the next command is accepted.
- R6: Step-in drives direction high and step-out drives it low. When bit 4 is 1 the track register moves by +1 (inward) or −1 (outward); when bit 4 is 0 it is left unchanged. A single-step command busies for P+1 cycles.
- R7: The plain step command reuses the direction left by the previous step.
- R8: With bit 2 set, a 30 ms settle follows the last step, and then the block waits for `vfy_ok_i`.
- R9: While waiting for verify, the fifth rising edge of `index_i` ends the command with `rnf_o` set.
- R10: With bit 3 clear and `motor_ready_i` low, no step is issued until `motor_ready_i` rises. With bit 3 set, stepping starts at once.
- R11: `busy_o` is high from the cycle after acceptance until the command ends. `not_trk0_o` is the inverse of `trk0_i`, delayed by one register.
- R12: `trk_wr_i` loads `trk_wdata_i` into the track register only in IDLE.
- R13: After reset the block is idle, with the track register at 0, direction low, the step output low and `rnf_o` low.
- R14: Each step pulse is high for the first `STEP_W` cycles of its period, and direction is stable for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command byte present this cycle |
| cmd_i | input | 8 | Command byte |
| tgt_i | input | 8 | Target track for seek |
| rate_tbl_i | input | 1 | Step rate table select |
| trk_wr_i | input | 1 | Load track register |
| trk_wdata_i | input | 8 | Value for track register load |
| motor_ready_i | input | 1 | Motor is up to speed |
| trk0_i | input | 1 | Head is at track zero |
| index_i | input | 1 | Index pulse from drive |
| vfy_ok_i | input | 1 | Verify-pass strobe |
| step_o | output | 1 | Step pulse to drive |
| dir_in_o | output | 1 | Step direction, 1 = inward |
| busy_o | output | 1 | Command in progress |
| not_trk0_o | output | 1 | Head not at track zero |
| rnf_o | output | 1 | Record not found |
| track_o | output | 8 | Track register |

## Verification
The bench counts the cycles between acceptance and the fall of busy. This interval is due at k·(P+1)+1 cycles for seek and restore, and at P+1 for a single step. Verify adds 30·`CYC_PER_MS`+1 more cycles. Step pulses, their width, the final track and the direction are all sampled at falling edges, once busy has fallen. A step-pulse monitor updates the modelled head position at the falling edge after each rising pulse, so track-zero reaches the block well before the next decision. The ignore, spin-up and index-timeout checks hold their stimulus for a fixed count of cycles and then sample busy and the step count before the next action.

// File: rtl/hss_pkg.sv
package hss_pkg;

    typedef enum logic [2:0] {
        OP_RESTORE,
        OP_SEEK,
        OP_STEP,
        OP_STEP_IN,
        OP_STEP_OUT,
        OP_NONE
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SPIN,
        S_DECIDE,
        S_STEP,
        S_SETTLE,
        S_VERIFY
    } st_e;

    typedef struct packed {
        op_e        op;
        logic       spin_skip;
        logic       verify;
        logic       upd;
        logic [1:0] rate;
    } cmd_t;

endpackage

// File: rtl/hss_decode.sv
module hss_decode
    import hss_pkg::*;
(
    input  logic [7:0] cmd_i,
    output cmd_t       dec_o
);

    always_comb begin
        dec_o.spin_skip = cmd_i[3];
        dec_o.verify    = cmd_i[2];
        dec_o.rate      = cmd_i[1:0];
        dec_o.upd       = 1'b1;
        dec_o.op        = OP_NONE;
        casez (cmd_i[7:4])
            4'b0000: dec_o.op = OP_RESTORE;
            4'b0001: dec_o.op = OP_SEEK;
            4'b001?: begin dec_o.op = OP_STEP;     dec_o.upd = cmd_i[4]; end
            4'b010?: begin dec_o.op = OP_STEP_IN;  dec_o.upd = cmd_i[4]; end
            4'b011?: begin dec_o.op = OP_STEP_OUT; dec_o.upd = cmd_i[4]; end
            default: dec_o.op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/hss_rate.sv
module hss_rate #(
    parameter int CYC_PER_MS = 125000,
    parameter int TW         = 22
) (
    input  logic          tbl_i,
    input  logic [1:0]    rate_i,
    output logic [TW-1:0] period_o
);

    logic [4:0] ms;

    always_comb begin
        unique case ({tbl_i, rate_i})
            3'b000, 3'b100: ms = 5'd6;
            3'b001, 3'b101: ms = 5'd12;
            3'b010:         ms = 5'd20;
            3'b011:         ms = 5'd30;
            3'b110:         ms = 5'd2;
            3'b111:         ms = 5'd3;
            default:        ms = 5'd6;
        endcase
        period_o = TW'(ms) * TW'(CYC_PER_MS);
    end

endmodule

// File: rtl/hss_timer.sv
module hss_timer #(
    parameter int TW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] lim_i,
    output logic [TW-1:0] elapsed_o,
    output logic          done_o
);

    logic [TW-1:0] elapsed_q;
    logic [TW-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
            lim_q     <= TW'(1);
        end else if (start_i) begin
            elapsed_q <= '0;
            lim_q     <= lim_i;
        end else if (elapsed_q != lim_q - TW'(1)) begin
            elapsed_q <= elapsed_q + TW'(1);
        end
    end

    assign elapsed_o = elapsed_q;
    assign done_o    = (elapsed_q == lim_q - TW'(1));

    // R2: the running count never passes the loaded period
    a_r2_elapsed_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed_q < lim_q);

endmodule

// File: rtl/hss_ctrl.sv
module hss_ctrl
    import hss_pkg::*;
#(
    parameter int TW          = 22,
    parameter int TRK_W       = 8,
    parameter int STEP_W      = 4,
    parameter int IDX_LIMIT   = 5,
    parameter int RESTORE_MAX = 255,
    parameter int SETTLE_CYC  = 3750000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  cmd_t             dec_i,
    input  logic [TW-1:0]    period_i,
    input  logic [TRK_W-1:0] tgt_i,
    input  logic             trk_wr_i,
    input  logic [TRK_W-1:0] trk_wdata_i,
    input  logic             motor_ready_i,
    input  logic             trk0_i,
    input  logic             index_i,
    input  logic             vfy_ok_i,
    input  logic             tmr_done_i,
    input  logic [TW-1:0]    tmr_elapsed_i,
    output logic             tmr_start_o,
    output logic [TW-1:0]    tmr_lim_o,
    output logic             step_o,
    output logic             dir_in_o,
    output logic             busy_o,
    output logic             not_trk0_o,
    output logic             rnf_o,
    output logic [TRK_W-1:0] track_o
);

    localparam int RW = $clog2(RESTORE_MAX + 1);
    localparam int IW = $clog2(IDX_LIMIT + 1);

    st_e              state_q, nxt;
    op_e              op_q;
    logic             ver_q, upd_q;
    logic [TW-1:0]    period_q;
    logic [TRK_W-1:0] tgt_q, track_q;
    logic             dir_q, rnf_q, trk0_q, idx_q;
    logic [RW-1:0]    rcnt_q;
    logic [IW-1:0]    icnt_q;

    logic accept, go_step, step_dir, zero_trk, set_rnf, finish, idx_rise;

    assign idx_rise = index_i & ~idx_q;

    // next state and control strobes
    always_comb begin
        nxt      = state_q;
        accept   = 1'b0;
        go_step  = 1'b0;
        step_dir = dir_q;
        zero_trk = 1'b0;
        set_rnf  = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid_i && dec_i.op != OP_NONE) begin
                    accept = 1'b1;
                    nxt = (!dec_i.spin_skip && !motor_ready_i) ? S_SPIN : S_DECIDE;
                end
            end
            S_SPIN: begin
                if (motor_ready_i) nxt = S_DECIDE;
            end
            S_DECIDE: begin
                unique case (op_q)
                    OP_RESTORE: begin
                        if (trk0_q) begin
                            zero_trk = 1'b1;
                            finish   = 1'b1;
                        end else if (rcnt_q == RW'(RESTORE_MAX)) begin
                            set_rnf = 1'b1;
                            nxt     = S_IDLE;
                        end else begin
                            go_step  = 1'b1;
                            step_dir = 1'b0;
                        end
                    end
                    OP_SEEK: begin
                        if (track_q == tgt_q) begin
                            finish = 1'b1;
                        end else begin
                            go_step  = 1'b1;
                            step_dir = (tgt_q > track_q);
                        end
                    end
                    OP_STEP: begin
                        go_step  = 1'b1;
                        step_dir = dir_q;
                    end
                    OP_STEP_IN: begin
                        go_step  = 1'b1;
                        step_dir = 1'b1;
                    end
                    OP_STEP_OUT: begin
                        go_step  = 1'b1;
                        step_dir = 1'b0;
                    end
                    default: nxt = S_IDLE;
                endcase
            end
            S_STEP: begin
                if (tmr_done_i) begin
                    if (op_q == OP_RESTORE || op_q == OP_SEEK) nxt = S_DECIDE;
                    else finish = 1'b1;
                end
            end
            S_SETTLE: begin
                if (tmr_done_i) nxt = S_VERIFY;
            end
            S_VERIFY: begin
                if (vfy_ok_i) begin
                    nxt = S_IDLE;
                end else if (idx_rise && icnt_q == IW'(IDX_LIMIT - 1)) begin
                    set_rnf = 1'b1;
                    nxt     = S_IDLE;
                end
            end
            default: nxt = S_IDLE;
        endcase

        if (go_step) nxt = S_STEP;
        if (finish)  nxt = ver_q ? S_SETTLE : S_IDLE;

        tmr_start_o = go_step || (finish && ver_q);
        tmr_lim_o   = (nxt == S_SETTLE) ? TW'(SETTLE_CYC) : period_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    // command fields, track register, counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            ver_q    <= 1'b0;
            upd_q    <= 1'b0;
            period_q <= TW'(1);
            tgt_q    <= '0;
            track_q  <= '0;
            dir_q    <= 1'b0;
            rnf_q    <= 1'b0;
            trk0_q   <= 1'b0;
            idx_q    <= 1'b0;
            rcnt_q   <= '0;
            icnt_q   <= '0;
        end else begin
            trk0_q <= trk0_i;
            idx_q  <= index_i;
            if (accept) begin
                op_q     <= dec_i.op;
                ver_q    <= dec_i.verify;
                upd_q    <= dec_i.upd;
                period_q <= period_i;
                tgt_q    <= tgt_i;
                rcnt_q   <= '0;
                rnf_q    <= 1'b0;
            end else if (trk_wr_i && state_q == S_IDLE) begin
                track_q <= trk_wdata_i;
            end
            if (go_step) begin
                dir_q <= step_dir;
                if (op_q == OP_RESTORE) rcnt_q <= rcnt_q + RW'(1);
                if (upd_q || op_q == OP_RESTORE || op_q == OP_SEEK)
                    track_q <= step_dir ? track_q + TRK_W'(1) : track_q - TRK_W'(1);
            end
            if (zero_trk) track_q <= '0;
            if (set_rnf)  rnf_q   <= 1'b1;
            if (state_q != S_VERIFY) icnt_q <= '0;
            else if (idx_rise)       icnt_q <= icnt_q + IW'(1);
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != S_IDLE);
        step_o     = (state_q == S_STEP) && (tmr_elapsed_i < TW'(STEP_W));
        dir_in_o   = dir_q;
        not_trk0_o = ~trk0_q;
        rnf_o      = rnf_q;
        track_o    = track_q;
    end

    // R12: an idle block changes the track register only through a host write
    a_r12_track_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && $past(state_q) == S_IDLE && !$past(trk_wr_i))
            |-> $stable(track_q));

    // R6: an inward step with update moves the track register up by one
    a_r6_inward_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && $past(state_q) == S_DECIDE && dir_q
            && (upd_q || op_q == OP_SEEK))
            |-> track_q == $past(track_q) + TRK_W'(1));

    // R6: an outward step with update moves the track register down by one
    a_r6_outward_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && $past(state_q) == S_DECIDE && !dir_q
            && (upd_q || op_q == OP_SEEK || op_q == OP_RESTORE))
            |-> track_q == $past(track_q) - TRK_W'(1));

    // R14: direction holds for the whole step period
    a_r14_dir_stable_in_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STEP && $past(state_q) == S_STEP) |-> $stable(dir_q));

    // R5 and R9: the not-found flag is raised only as the command ends
    a_r5_rnf_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rnf_q) |-> state_q == S_IDLE);

    // R10: no step pulse while waiting for the motor
    a_r10_no_step_in_spin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SPIN) |=> !(state_q == S_STEP && $past(state_q) == S_SPIN));

endmodule

// File: rtl/head_step_seq.sv
module head_step_seq
    import hss_pkg::*;
#(
    parameter int CYC_PER_MS  = 125000,
    parameter int STEP_W      = 4,
    parameter int IDX_LIMIT   = 5,
    parameter int RESTORE_MAX = 255,
    parameter int SETTLE_MS   = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_i,
    input  logic [7:0] tgt_i,
    input  logic       rate_tbl_i,
    input  logic       trk_wr_i,
    input  logic [7:0] trk_wdata_i,
    input  logic       motor_ready_i,
    input  logic       trk0_i,
    input  logic       index_i,
    input  logic       vfy_ok_i,
    output logic       step_o,
    output logic       dir_in_o,
    output logic       busy_o,
    output logic       not_trk0_o,
    output logic       rnf_o,
    output logic [7:0] track_o
);

    localparam int TRK_W      = 8;
    localparam int MAX_MS     = (SETTLE_MS > 30) ? SETTLE_MS : 30;
    localparam int TW         = $clog2(MAX_MS * CYC_PER_MS + 1);
    localparam int SETTLE_CYC = SETTLE_MS * CYC_PER_MS;

    cmd_t          dec;
    logic [TW-1:0] period;
    logic          tmr_start, tmr_done;
    logic [TW-1:0] tmr_lim, tmr_elapsed;

    hss_decode u_decode (
        .cmd_i (cmd_i),
        .dec_o (dec)
    );

    hss_rate #(.CYC_PER_MS(CYC_PER_MS), .TW(TW)) u_rate (
        .tbl_i    (rate_tbl_i),
        .rate_i   (dec.rate),
        .period_o (period)
    );

    hss_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (tmr_start),
        .lim_i     (tmr_lim),
        .elapsed_o (tmr_elapsed),
        .done_o    (tmr_done)
    );

    hss_ctrl #(
        .TW(TW), .TRK_W(TRK_W), .STEP_W(STEP_W), .IDX_LIMIT(IDX_LIMIT),
        .RESTORE_MAX(RESTORE_MAX), .SETTLE_CYC(SETTLE_CYC)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid_i   (cmd_valid_i),
        .dec_i         (dec),
        .period_i      (period),
        .tgt_i         (tgt_i),
        .trk_wr_i      (trk_wr_i),
        .trk_wdata_i   (trk_wdata_i),
        .motor_ready_i (motor_ready_i),
        .trk0_i        (trk0_i),
        .index_i       (index_i),
        .vfy_ok_i      (vfy_ok_i),
        .tmr_done_i    (tmr_done),
        .tmr_elapsed_i (tmr_elapsed),
        .tmr_start_o   (tmr_start),
        .tmr_lim_o     (tmr_lim),
        .step_o        (step_o),
        .dir_in_o      (dir_in_o),
        .busy_o        (busy_o),
        .not_trk0_o    (not_trk0_o),
        .rnf_o         (rnf_o),
        .track_o       (track_o)
    );

endmodule

// File: tb/tb_head_step_seq.sv
`timescale 1ns/1ps
module tb_head_step_seq;

    localparam int CPM   = 2;
    localparam int STW   = 2;
    localparam int SETTL = 30 * CPM;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd = '0;
    logic [7:0] tgt = '0;
    logic       tbl = 1'b0;
    logic       trk_wr = 1'b0;
    logic [7:0] trk_wdata = '0;
    logic       motor_ready = 1'b0;
    logic       trk0;
    logic       index_in = 1'b0;
    logic       vfy_ok = 1'b0;
    logic       step, dir_in, busy, not_trk0, rnf;
    logic [7:0] track;

    always #4 clk = ~clk;

    head_step_seq #(.CYC_PER_MS(CPM), .STEP_W(STW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
        .tgt_i(tgt), .rate_tbl_i(tbl), .trk_wr_i(trk_wr), .trk_wdata_i(trk_wdata),
        .motor_ready_i(motor_ready), .trk0_i(trk0), .index_i(index_in),
        .vfy_ok_i(vfy_ok), .step_o(step), .dir_in_o(dir_in), .busy_o(busy),
        .not_trk0_o(not_trk0), .rnf_o(rnf), .track_o(track)
    );

    // drive model: head position = base (set by tests) + offset (moved by pulses)
    int head_base = 0;
    int head_off  = 0;
    int nsteps    = 0;
    int wcur      = 0;
    int lastw     = 0;
    logic step_prev = 1'b0;

    assign trk0 = ((head_base + head_off) == 0);

    always @(negedge clk) begin
        if (step && !step_prev) begin
            nsteps = nsteps + 1;
            if (dir_in) head_off = head_off + 1;
            else if ((head_base + head_off) > 0) head_off = head_off - 1;
        end
        if (step) wcur = wcur + 1;
        else if (step_prev) begin
            lastw = wcur;
            wcur  = 0;
        end
        step_prev = step;
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_head(input int pos);
        head_base = pos - head_off;
    endtask

    task automatic load_track(input logic [7:0] v);
        @(negedge clk);
        trk_wr = 1'b1;
        trk_wdata = v;
        @(negedge clk);
        trk_wr = 1'b0;
    endtask

    // issue a command and return the number of busy cycles seen
    task automatic issue(input logic [7:0] c, output int bcyc);
        @(negedge clk);
        cmd = c;
        cmd_valid = 1'b1;
        bcyc = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (!busy) break;
            bcyc++;
        end
    endtask

    typedef struct packed {
        logic [7:0]  cmd;
        logic        sel;
        logic [7:0]  trk;
        logic [7:0]  head;
        logic [7:0]  tgt;
        logic [8:0]  nstep;
        logic [7:0]  etrk;
        logic        edir;
        logic [15:0] ebusy;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{8'h18, 1'b0, 8'd3,  8'd3,  8'd7, 9'd4, 8'd7, 1'b1, 16'd53},
        '{8'h1B, 1'b1, 8'd10, 8'd10, 8'd6, 9'd4, 8'd6, 1'b0, 16'd29},
        '{8'h1A, 1'b1, 8'd5,  8'd5,  8'd5, 9'd0, 8'd5, 1'b0, 16'd1},
        '{8'h19, 1'b0, 8'd0,  8'd0,  8'd2, 9'd2, 8'd2, 1'b1, 16'd51},
        '{8'h5A, 1'b1, 8'd2,  8'd2,  8'd0, 9'd1, 8'd3, 1'b1, 16'd5},
        '{8'h6A, 1'b1, 8'd3,  8'd3,  8'd0, 9'd1, 8'd3, 1'b0, 16'd5},
        '{8'h3A, 1'b1, 8'd3,  8'd3,  8'd0, 9'd1, 8'd2, 1'b0, 16'd5},
        '{8'h0A, 1'b1, 8'd9,  8'd4,  8'd0, 9'd4, 8'd0, 1'b0, 16'd21},
        '{8'h0B, 1'b0, 8'd50, 8'd1,  8'd0, 9'd1, 8'd0, 1'b0, 16'd62},
        '{8'h4A, 1'b0, 8'd7,  8'd7,  8'd0, 9'd1, 8'd7, 1'b1, 16'd41}
    };

    task automatic run_all();
        int b, s0;
        // R13 reset state
        @(negedge clk);
        chk("R13 busy", busy, 0);
        chk("R13 step", step, 0);
        chk("R13 track", track, 0);
        chk("R13 dir", dir_in, 0);
        chk("R13 rnf", rnf, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 not_trk0 at zero", not_trk0, 0);

        // table of vectors; motor not ready proves R10 skip with bit 3 set
        for (int i = 0; i < 10; i++) begin
            vec_t v;
            v = VEC[i];
            set_head(int'(v.head));
            tgt = v.tgt;
            tbl = v.sel;
            load_track(v.trk);
            s0 = nsteps;
            issue(v.cmd, b);
            chk("R3/R4/R6 steps", nsteps - s0, int'(v.nstep));
            chk("R3/R4/R6 track", track, int'(v.etrk));
            chk("R6/R7 dir", dir_in, int'(v.edir));
            chk("R2/R3/R10 busy cycles", b, int'(v.ebusy));
            if (v.nstep != 0) chk("R14 pulse width", lastw, STW);
        end

        // R11 track-zero status follows the sensor one register later
        set_head(0);
        repeat (2) @(negedge clk);
        chk("R11 not_trk0 low", not_trk0, 0);
        set_head(3);
        repeat (2) @(negedge clk);
        chk("R11 not_trk0 high", not_trk0, 1);

        // R1 bytes with bit 7 set are ignored
        s0 = nsteps;
        issue(8'h80, b);
        chk("R1 ignore 80 busy", b, 0);
        issue(8'hD0, b);
        chk("R1 ignore D0 busy", b, 0);
        chk("R1 ignore steps", nsteps - s0, 0);

        // R1 and R12: a command and a track write during a seek have no effect
        set_head(0);
        tbl = 1'b0;
        tgt = 8'd5;
        load_track(8'd0);
        s0 = nsteps;
        @(negedge clk);
        cmd = 8'h18;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        cmd = 8'h5A;
        cmd_valid = 1'b1;
        trk_wr = 1'b1;
        trk_wdata = 8'd99;
        tgt = 8'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        trk_wr = 1'b0;
        for (int g = 0; g < 2000 && busy; g++) @(negedge clk);
        chk("R1 busy command ignored steps", nsteps - s0, 5);
        chk("R12 write while busy ignored", track, 5);
        load_track(8'd42);
        chk("R12 write while idle", track, 42);

        // R5 restore gives up after 255 steps
        set_head(300);
        tbl = 1'b1;
        s0 = nsteps;
        issue(8'h0A, b);
        chk("R5 steps", nsteps - s0, 255);
        chk("R5 busy cycles", b, 255 * 5 + 1);
        chk("R5 rnf set", rnf, 1);

        // R8 verify adds settle, passes on strobe; rnf clears on accept
        set_head(0);
        tgt = 8'd1;
        load_track(8'd0);
        vfy_ok = 1'b1;
        issue(8'h1E, b);
        chk("R8 busy cycles", b, 5 + 1 + SETTL + 1);
        chk("R5 rnf cleared by new command", rnf, 0);
        vfy_ok = 1'b0;

        // R9 five index edges while verifying end with rnf
        @(negedge clk);
        cmd = 8'h5E;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (80) @(negedge clk);
        chk("R8 waits for strobe", busy, 1);
        for (int k = 0; k < 4; k++) begin
            index_in = 1'b1;
            @(negedge clk);
            index_in = 1'b0;
            @(negedge clk);
        end
        chk("R9 busy after four edges", busy, 1);
        index_in = 1'b1;
        @(negedge clk);
        index_in = 1'b0;
        @(negedge clk);
        chk("R9 ends after fifth edge", busy, 0);
        chk("R9 rnf", rnf, 1);

        // R10 spin-up wait with bit 3 clear
        motor_ready = 1'b0;
        s0 = nsteps;
        @(negedge clk);
        cmd = 8'h52;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 busy while spinning", busy, 1);
        chk("R10 no step while spinning", nsteps - s0, 0);
        motor_ready = 1'b1;
        for (int g = 0; g < 200 && busy; g++) @(negedge clk);
        chk("R10 step after ready", nsteps - s0, 1);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule